// File: doc/BRIEF.md
# Two-phase transition-signalled pipeline controller

This block is a clocked model of an N-stage pipeline in which each stage passes data to the next through a request/acknowledge pair that signals by transition. Any toggle on a request or acknowledge wire is one event, and the level of the wire has no meaning. Each stage has a data latch, a small datapath function and a control cell. The control cell is a state register that acts as a C-element, an XOR that drives the latch enable, and a delay chain that holds back the outgoing request. At rest every latch is open. A stage closes its latch when it takes in a request event and opens it again when the following stage acknowledges. When items arrive far apart, the whole chain is therefore one combinational path from `data_i` to `data_o`. When they arrive close together, the closed latches split that path into shorter segments.

A producer toggles `req_i` while `data_i` is stable and sees that the item was taken when `ack_o` toggles. A consumer sees a new item when `req_o` toggles and frees the last stage by toggling `ack_i`. With `loopback_i` set, the block acknowledges its own output one cycle after each output event, so a test setup cannot deadlock. The `lock_o` vector and the `depth_o` count let a testbench see how many stages are closed as the input spacing changes.

Top module: `tp_pipe`

## Requirements
- R1: While `rst_ni` is low, and up to the first input event after it rises, `lock_o`, `req_o`, `ack_o` and `depth_o` are all zero.
- R2: When `req_i` differs from `ack_o` and stage 0 is open, `ack_o` toggles after the next rising clock edge. `ack_o` never toggles unless `req_i` differed from it in the cycle before.
- R3: Bit k of `lock_o` is 1 while stage k holds an item that stage k+1 (or the consumer, for the last stage) has not yet acknowledged. The bit is 0 while the stage is transparent. The bit rises only on a clock edge at which the stage takes in a request event.
- R4: When no item is in flight, all `lock_o` bits are 0 and `data_o` equals `data_i + N*ADD_K` (modulo 2^W) in the same cycle, with no clock edge in between.
- R5: In an empty pipeline, `req_o` toggles exactly `N*(DLY+1)` rising edges after the edge that samples a `req_i` toggle.
- R6: At each `req_o` event, `data_o` equals the oldest input item not yet delivered, plus `N*ADD_K`. Every item is delivered exactly once and in input order, whether the input is sparse, back-to-back or stalled.
- R7: With `loopback_i` low and `ack_i` held, the block accepts exactly N items. It then sets every `lock_o` bit and stops toggling `ack_o`.
- R8: With `loopback_i` high, `ack_i` is ignored and each `req_o` event is acknowledged internally one cycle later. The last `lock_o` bit is 1 in the cycle after the event and 0 in the cycle after that.
- R9: One clock edge after each `req_o` event, `depth_o` loads the number of `lock_o` bits that are set in the cycle after that event. It never exceeds N, and it reads 1 when items are far apart.
- R10: `req_o` toggles only while the last stage is locked, and `data_o` stays stable while the last stage remains locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loopback_i | input | 1 | 1: output events are acknowledged internally |
| data_i | input | W | Input data item |
| req_i | input | 1 | Input request, one event per toggle |
| ack_o | output | 1 | Input acknowledge, one event per toggle |
| data_o | output | W | Output data item |
| req_o | output | 1 | Output request, one event per toggle |
| ack_i | input | 1 | Output acknowledge, one event per toggle; ignored in loopback |
| lock_o | output | N | Latch state per stage, 1 = locked |
| depth_o | output | $clog2(N+1) | Locked-stage count sampled after each output event |

## Verification
`ack_o` is due one edge after `req_i` is sampled. The first output event from an empty pipeline is due `N*(DLY+1)` edges later. The internal loopback acknowledge adds one more edge, and `depth_o` follows each output event by one edge. The bench drives inputs at the falling edge and reads outputs at the next falling edge. It counts falling edges from a stimulus, so each expected value is checked in the exact cycle it is due. Checks that do not depend on cycle timing, such as the transparent path and data order, are made at output events or half a cycle after `data_i` changes.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic {DP_PASS, DP_ADD} dp_kind_e;
endpackage

// File: rtl/tp_stage_ctrl.sv
module tp_stage_ctrl #(
  parameter int unsigned DLY = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ack_i,
  output logic cap_o,
  output logic phase_o,
  output logic lock_o,
  output logic req_o
);
  logic           phase_q;
  logic [DLY-1:0] dly_q;

  // C-element of req and inverted ack: follows req when req != ack
  assign cap_o   = (req_i ^ ack_i) & (req_i ^ phase_q);
  assign phase_o = phase_q;
  assign lock_o  = phase_q ^ ack_i;
  assign req_o   = dly_q[DLY-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              phase_q <= 1'b0;
    else if (req_i ^ ack_i)   phase_q <= req_i;
  end

  // matched bundling delay
  if (DLY == 1) begin : g_dly_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dly_q <= '0;
      else         dly_q <= phase_q;
    end
  end else begin : g_dly_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dly_q <= '0;
      else         dly_q <= {dly_q[DLY-2:0], phase_q};
    end
  end
endmodule

// File: rtl/tp_stage_dp.sv
module tp_stage_dp
  import tp_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter dp_kind_e    KIND  = DP_ADD,
  parameter int unsigned ADD_K = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic         lock_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  logic [W-1:0] fn;
  logic [W-1:0] hold_q;

  if (KIND == DP_ADD) begin : g_add
    assign fn = d_i + W'(ADD_K);
  end else begin : g_pass
    assign fn = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (cap_i) hold_q <= fn;
  end

  // open latch passes straight through
  assign d_o = lock_i ? hold_q : fn;
endmodule

// File: rtl/tp_pipe.sv
module tp_pipe
  import tp_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned W     = 8,
  parameter int unsigned ADD_K = 3,
  parameter int unsigned DLY   = 1,
  localparam int unsigned DW   = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          loopback_i,
  input  logic [W-1:0]  data_i,
  input  logic          req_i,
  output logic          ack_o,
  output logic [W-1:0]  data_o,
  output logic          req_o,
  input  logic          ack_i,
  output logic [N-1:0]  lock_o,
  output logic [DW-1:0] depth_o
);
  localparam dp_kind_e KIND = (ADD_K == 0) ? DP_PASS : DP_ADD;

  logic [N:0]    req_v;
  logic [N-1:0]  phase_v;
  logic [N-1:0]  lock_v;
  logic          lb_q;
  logic          ack_last;
  logic          req_q;
  logic [DW-1:0] depth_q;

  assign req_v[0] = req_i;
  assign ack_last = loopback_i ? lb_q : ack_i;

  for (genvar k = 0; k < N; k++) begin : g_st
    logic         ack_k;
    logic         cap_k;
    logic [W-1:0] din_k;
    logic [W-1:0] dout;

    if (k == N - 1) begin : g_tail
      assign ack_k = ack_last;
    end else begin : g_body
      assign ack_k = phase_v[k+1];
    end

    if (k == 0) begin : g_head
      assign din_k = data_i;
    end else begin : g_link
      assign din_k = g_st[k-1].dout;
    end

    tp_stage_ctrl #(.DLY(DLY)) u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_v[k]),
      .ack_i   (ack_k),
      .cap_o   (cap_k),
      .phase_o (phase_v[k]),
      .lock_o  (lock_v[k]),
      .req_o   (req_v[k+1])
    );

    tp_stage_dp #(.W(W), .KIND(KIND), .ADD_K(ADD_K)) u_dp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (cap_k),
      .lock_i (lock_v[k]),
      .d_i    (din_k),
      .d_o    (dout)
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lb_q    <= 1'b0;
      req_q   <= 1'b0;
      depth_q <= '0;
    end else begin
      lb_q  <= req_v[N];
      req_q <= req_v[N];
      if (req_v[N] != req_q) depth_q <= DW'($countones(lock_v));
    end
  end

  assign ack_o   = phase_v[0];
  assign req_o   = req_v[N];
  assign data_o  = g_st[N-1].dout;
  assign lock_o  = lock_v;
  assign depth_o = depth_q;
endmodule

// File: rtl/tp_pipe_chk.sv
module tp_pipe_chk #(
  parameter int unsigned N  = 4,
  parameter int unsigned W  = 8,
  localparam int unsigned DW = $clog2(N + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          ack_o,
  input logic          req_o,
  input logic [W-1:0]  data_o,
  input logic [N-1:0]  lock_o,
  input logic [DW-1:0] depth_o
);
  a_r2_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ack_o) |-> ($past(req_i) != $past(ack_o)));

  a_r3_lock_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o[0]) |-> ($past(req_i) != $past(ack_o)));

  a_r9_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(depth_o) |-> (depth_o <= DW'(N)));

  a_r10_req_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(req_o) |-> $past(lock_o[N-1]));

  a_r10_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o[N-1] && $past(lock_o[N-1])) |-> $stable(data_o));
endmodule

bind tp_pipe tp_pipe_chk #(.N(N), .W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .ack_o   (ack_o),
  .req_o   (req_o),
  .data_o  (data_o),
  .lock_o  (lock_o),
  .depth_o (depth_o)
);

// File: tb/tp_pipe_bench.sv
module tp_pipe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = 8;
  localparam int ADD_K = 3;
  localparam int DLY = 1;
  localparam int LAT = N * (DLY + 1);
  localparam int DW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lb;
  logic [W-1:0]  din;
  logic          req_in;
  logic          ack_out;
  logic [W-1:0]  dout;
  logic          req_out;
  logic          ack_in;
  logic [N-1:0]  lock;
  logic [DW-1:0] depth;

  int total = 0;
  int bad = 0;
  int n_in = 0;
  int n_out = 0;
  bit sparse = 1'b0;
  bit consumer = 1'b0;
  bit done = 1'b0;
  logic [W-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tp_pipe #(.N(N), .W(W), .ADD_K(ADD_K), .DLY(DLY)) u_tp_pipe (
    .clk_i(clk), .rst_ni(rst_n), .loopback_i(lb), .data_i(din), .req_i(req_in),
    .ack_o(ack_out), .data_o(dout), .req_o(req_out), .ack_i(ack_in),
    .lock_o(lock), .depth_o(depth)
  );

  function automatic logic [W-1:0] xf(logic [W-1:0] v);
    return W'(v + N * ADD_K);
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic push_item(logic [W-1:0] v);
    din = v;
    req_in = ~req_in;
    exp_q.push_back(xf(v));
    n_in++;
  endtask

  // returns 1 when stage 0 is free within the wait window
  task automatic wait_ready(int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if (ack_out == req_in) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic drain(int lim);
    for (int i = 0; i < lim && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // reference model: order, loss, duplication, depth
  initial begin
    logic prev = 1'b0;
    bit   pend = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pend) begin
          pend = 1'b0;
          chk(depth <= DW'(N), "R9 depth bound", int'(depth), N);
          if (sparse) chk(depth == 1, "R9 sparse depth", int'(depth), 1);
        end
        if (req_out != prev) begin
          n_out++;
          pend = 1'b1;
          if (exp_q.size() == 0) chk(1'b0, "R6 extra item", int'(dout), -1);
          else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            chk(dout == e, "R6 order", int'(dout), int'(e));
          end
          if (consumer) ack_in = ~ack_in;
        end
        prev = req_out;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit ok;
    int k;
    int sent;
    logic lvl;
    rst_n = 1'b0; lb = 1'b1; din = '0; req_in = 1'b0; ack_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(lock == '0 && req_out == 1'b0 && ack_out == 1'b0 && depth == '0,
        "R1 reset state", int'(lock), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lock == '0 && depth == '0, "R1 after release", int'(lock), 0);

    // sparse items, loopback on, ack_in toggled to show it is ignored (R8)
    sparse = 1'b1;
    for (int i = 0; i < 5; i++) begin
      lvl = req_out;
      push_item(W'(i * 37 + 5));
      ack_in = ~ack_in;
      chk(ack_out != req_in, "R2 no early ack", int'(ack_out), int'(~req_in));
      @(negedge clk);
      chk(ack_out == req_in, "R2 ack one edge", int'(ack_out), int'(req_in));
      chk(lock[0] == 1'b1, "R3 lock on accept", int'(lock[0]), 1);
      k = 1;
      while (req_out == lvl && k < 50) begin @(negedge clk); k++; end
      chk(k == LAT, "R5 latency", k, LAT);
      chk(lock[N-1] == 1'b1, "R8 last locked at event", int'(lock[N-1]), 1);
      @(negedge clk);
      chk(lock[N-1] == 1'b0, "R8 loopback ack", int'(lock[N-1]), 0);
      repeat (6) @(negedge clk);
    end

    // idle: fully transparent combinational path
    chk(lock == '0, "R4 all open", int'(lock), 0);
    for (int v = 0; v < 256; v += 85) begin
      din = W'(v);
      #1;
      chk(dout == xf(W'(v)), "R4 transparent path", int'(dout), int'(xf(W'(v))));
      @(negedge clk);
    end

    // back-to-back items
    sparse = 1'b0;
    for (int i = 0; i < 24; i++) begin
      wait_ready(40, ok);
      chk(ok, "R6 dense ready", int'(ok), 1);
      push_item(W'(i * 13 + 200));
      @(negedge clk);
    end
    drain(300);
    chk(exp_q.size() == 0, "R6 dense drained", exp_q.size(), 0);

    // stalled consumer
    ack_in = req_out;
    lb = 1'b0;
    @(negedge clk);
    sent = 0;
    for (int i = 0; i < N + 2; i++) begin
      wait_ready(30, ok);
      if (!ok) break;
      push_item(W'(i * 29 + 1));
      sent++;
      @(negedge clk);
    end
    chk(sent == N + 1, "R7 accepted count", sent - 1, N);
    chk(ack_out != req_in, "R7 ack stopped", int'(ack_out), int'(~req_in));
    chk(lock == '1, "R7 all locked", int'(lock), (1 << N) - 1);
    repeat (5) @(negedge clk);
    chk(lock == '1, "R7 still locked", int'(lock), (1 << N) - 1);

    // consumer resumes: ack pending event, then every later one
    ack_in = req_out;
    consumer = 1'b1;
    drain(300);
    chk(exp_q.size() == 0, "R6 stall drained", exp_q.size(), 0);
    chk(n_out == n_in, "R6 no loss or dup", n_out, n_in);
    chk(lock == '0, "R3 open after drain", int'(lock), 0);
    finish_run();
  end
endmodule